// File: doc/BRIEF.md
# Conversion Queue Trigger Controller

This block decides when each conversion queue of a queued analog-to-digital converter begins a single pass through its conversion list. Software programs a per-queue operating mode and arms the queue through a write-only single-scan enable. Once a queue is armed, the trigger event that belongs to its mode starts it: a software start, a rising edge on an external trigger pin, a high level on an external gate pin, or a tick from an interval timer.

When a trigger is accepted, the block issues a one-cycle start pulse to the queue sequencer and raises the queue's active flag. The sequencer reports the end of the pass on a completion input. Completion drops the active flag and disarms the queue, so software must arm it again before the next pass. The block also reports when neither queue is in a working mode. In that state the conversion RAM can be accessed without wait states and the converter clock prescaler may be reprogrammed.

The external trigger and gate pins are asynchronous and pass through a synchronizer of parameterised depth. The timer tick comes from the same clock domain and is used directly. The second queue cannot run in gated mode. A code outside the working set, including the reserved code, leaves a queue idle in the same way the disabled code does.

Top module: `conv_queue_trig`

## Requirements
- R1: After reset every queue holds mode code 000, no start pulse or active flag is raised, `all_off` is 1 and `reg_rdata` reads 0.
- R2: Mode codes 000, 101, 110 and 111 (111 is the reserved code) are idle modes. With such a code, no trigger of any kind raises a start pulse or the active flag, even when the enable bit was written as 1.
- R3: A write with `reg_we`=1 stores `reg_wdata[2:0]` as the mode code of the queue chosen by `reg_sel` (0 = first queue, 1 = second queue), and `reg_wdata[3]` is the single-scan enable. `reg_rdata` returns the stored code of the selected queue in bits 2:0, with bit 3 always 0. Writing 0 to bit 3 does not disarm an armed queue.
- R4: In a working mode, triggers are ignored while the queue is not armed.
- R5: Code 001 (software single-scan) with the enable written as 1 raises `start_out` in the first cycle after the write, for one cycle, and then raises `active_out`.
- R6: Code 010 (external trigger) starts an armed queue on a rising edge of `trig_in`. `start_out` is seen `SYNC_STAGES` cycles after the edge is driven. A held high level starts nothing further.
- R7: Code 011 (gated) on the first queue starts an armed queue while the synchronized `gate_in` is high. A low gate drops `active_out` and keeps the queue armed, so a new high level restarts it.
- R8: Code 011 written to the second queue is an idle mode.
- R9: Code 100 (interval) starts an armed queue in the same cycle that `tick_in` is high.
- R10: A `done_in` pulse while active drops `active_out` and disarms the queue, so later triggers are ignored until the queue is armed again.
- R11: An arming write to a queue in the same cycle as its `done_in` leaves the queue armed.
- R12: `all_off` is 1 exactly when every queue holds an idle code. While `all_off` is 1, no queue is active.
- R13: `start_out` is only raised while the queue is not active, so each pass gives exactly one start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Queue selected for write and read |
| reg_wdata | input | 4 | {enable, mode code} |
| reg_rdata | output | 4 | {0, stored mode code} of the selected queue |
| trig_in | input | NUM_Q | Asynchronous external trigger per queue |
| gate_in | input | NUM_Q | Asynchronous external gate per queue |
| tick_in | input | NUM_Q | Interval timer tick per queue, same clock domain |
| done_in | input | NUM_Q | Pass completion from the sequencer |
| start_out | output | NUM_Q | One-cycle start pulse per queue |
| active_out | output | NUM_Q | Queue is executing a pass |
| all_off | output | 1 | Every queue idle: no RAM wait states, prescaler change safe |

## Verification
Two events can fall in the same cycle here: the sequencer signalling completion, and software re-arming that same queue. The bench provokes this collision by driving `done_in` and an arming write to the interval-mode queue on one clock edge. It then judges the outcome at the ports: `active_out` must be low, no start may appear without a tick, and a later tick must produce a start pulse, which shows the arm survived. A sweep over every mode code on both queues, with all trigger kinds applied together, checks that each code starts exactly one pass or none.

// File: rtl/cqtrig_pkg.sv
package cqtrig_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [2:0] {
      K_OFF  = 3'd0,
      K_SW   = 3'd1,
      K_EXT  = 3'd2,
      K_GATE = 3'd3,
      K_TMR  = 3'd4
   } kind_e;

   // Map a stored mode code to a behaviour; anything unlisted idles.
   function automatic kind_e decode_mode(input logic [MODE_W-1:0] code,
                                         input logic gated_ok);
      kind_e k;
      case (code)
         3'b001:  k = K_SW;
         3'b010:  k = K_EXT;
         3'b011:  k = gated_ok ? K_GATE : K_OFF;
         3'b100:  k = K_TMR;
         default: k = K_OFF;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/cqtrig_sync.sv
module cqtrig_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/cqtrig_queue.sv
module cqtrig_queue
   import cqtrig_pkg::*;
#(
   parameter bit GATED_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_code,
   input  logic              wr_sse,
   input  logic              trig_lvl,
   input  logic              gate_lvl,
   input  logic              tick,
   input  logic              done,
   output logic [MODE_W-1:0] code_o,
   output logic              start_o,
   output logic              active_o,
   output logic              off_o
);

   logic [MODE_W-1:0] code_q;
   logic              armed_q;
   logic              active_q;
   logic              trig_prev_q;
   kind_e             kind;
   kind_e             wr_kind;
   logic              evt;
   logic              accept;
   logic              wr_idle;

   assign kind    = decode_mode(code_q, GATED_OK);
   assign wr_kind = decode_mode(wr_code, GATED_OK);
   assign wr_idle = wr_en && (wr_kind == K_OFF);

   always_comb begin
      case (kind)
         K_SW:    evt = 1'b1;
         K_EXT:   evt = trig_lvl && !trig_prev_q;
         K_GATE:  evt = gate_lvl;
         K_TMR:   evt = tick;
         default: evt = 1'b0;
      endcase
   end

   assign accept = armed_q && !active_q && evt && (kind != K_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q      <= '0;
         armed_q     <= 1'b0;
         active_q    <= 1'b0;
         trig_prev_q <= 1'b0;
      end else begin
         trig_prev_q <= trig_lvl;
         if (wr_en) code_q <= wr_code;

         // Arming write wins over completion in the same cycle.
         if (wr_en && wr_sse && (wr_kind != K_OFF))
            armed_q <= 1'b1;
         else if (wr_idle || (kind == K_OFF) || (done && active_q))
            armed_q <= 1'b0;

         if (wr_idle || (kind == K_OFF))
            active_q <= 1'b0;
         else if (accept)
            active_q <= 1'b1;
         else if (done)
            active_q <= 1'b0;
         else if ((kind == K_GATE) && !gate_lvl)
            active_q <= 1'b0;
      end
   end

   assign code_o   = code_q;
   assign start_o  = accept;
   assign active_o = active_q;
   assign off_o    = (kind == K_OFF);

endmodule

// File: rtl/conv_queue_trig.sv
module conv_queue_trig
   import cqtrig_pkg::*;
#(
   parameter int              NUM_Q       = 2,
   parameter int              SYNC_STAGES = 2,
   parameter logic [NUM_Q-1:0] GATED_MASK = 2'b01,
   localparam int             SEL_W       = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
   localparam int             DATA_W      = MODE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_Q-1:0]  trig_in,
   input  logic [NUM_Q-1:0]  gate_in,
   input  logic [NUM_Q-1:0]  tick_in,
   input  logic [NUM_Q-1:0]  done_in,
   output logic [NUM_Q-1:0]  start_out,
   output logic [NUM_Q-1:0]  active_out,
   output logic              all_off
);

   if (NUM_Q < 1) begin : g_bad_nq
      $error("conv_queue_trig: NUM_Q must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("conv_queue_trig: SYNC_STAGES must be at least 2");
   end

   logic [NUM_Q-1:0]        trig_s;
   logic [NUM_Q-1:0]        gate_s;
   logic [NUM_Q-1:0]        off_v;
   logic [NUM_Q*MODE_W-1:0] modes_flat;

   cqtrig_sync #(.STAGES(SYNC_STAGES), .WIDTH(2*NUM_Q)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({gate_in, trig_in}),
      .q     ({gate_s, trig_s})
   );

   for (genvar i = 0; i < NUM_Q; i++) begin : g_q
      logic wr_en_i;
      assign wr_en_i = reg_we && (reg_sel == SEL_W'(i));

      cqtrig_queue #(.GATED_OK(GATED_MASK[i])) u_queue (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en_i),
         .wr_code  (reg_wdata[MODE_W-1:0]),
         .wr_sse   (reg_wdata[MODE_W]),
         .trig_lvl (trig_s[i]),
         .gate_lvl (gate_s[i]),
         .tick     (tick_in[i]),
         .done     (done_in[i]),
         .code_o   (modes_flat[i*MODE_W +: MODE_W]),
         .start_o  (start_out[i]),
         .active_o (active_out[i]),
         .off_o    (off_v[i])
      );
   end

   // Enable bit is write-only: readback carries only the stored code.
   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_Q; i++)
         if (reg_sel == SEL_W'(i))
            reg_rdata = {1'b0, modes_flat[i*MODE_W +: MODE_W]};
   end

   assign all_off = &off_v;

endmodule

// File: rtl/conv_queue_trig_chk.sv
module conv_queue_trig_chk #(
   parameter int               NUM_Q      = 2,
   parameter logic [NUM_Q-1:0] GATED_MASK = 2'b01
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [3:0]         reg_rdata,
   input logic [NUM_Q-1:0]   done_in,
   input logic [NUM_Q-1:0]   start_out,
   input logic [NUM_Q-1:0]   active_out,
   input logic               all_off,
   input logic [NUM_Q*3-1:0] modes_flat
);

   assert_rdata_sse_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[3] == 1'b0);

   assert_all_off_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |-> (active_out == '0));

   for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
      logic [2:0] code_i;
      assign code_i = modes_flat[i*3 +: 3];

      assert_start_when_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
         start_out[i] |-> !active_out[i]);

      assert_start_then_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (start_out[i] && !reg_we) |=> active_out[i]);

      assert_done_drops_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (done_in[i] && active_out[i]) |=> !active_out[i]);

      assert_idle_code_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ((code_i == 3'b000) || (code_i >= 3'b101)) |-> (!start_out[i] && !active_out[i]));

      if (!GATED_MASK[i]) begin : g_nogate
         assert_no_gated_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (code_i == 3'b011) |-> !start_out[i]);
      end
   end

endmodule

bind conv_queue_trig conv_queue_trig_chk #(.NUM_Q(NUM_Q), .GATED_MASK(GATED_MASK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_rdata  (reg_rdata),
   .done_in    (done_in),
   .start_out  (start_out),
   .active_out (active_out),
   .all_off    (all_off),
   .modes_flat (modes_flat)
);

// File: tb/conv_queue_trig_test.sv
module conv_queue_trig_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [0:0] reg_sel = '0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic [1:0] trig_in = '0, gate_in = '0, tick_in = '0, done_in = '0;
   logic [1:0] start_out, active_out;
   logic       all_off;

   int  checks = 0;
   int  failures = 0;
   bit  finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   conv_queue_trig uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .trig_in(trig_in), .gate_in(gate_in), .tick_in(tick_in), .done_in(done_in),
      .start_out(start_out), .active_out(active_out), .all_off(all_off)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Write {sse, code} to queue q; returns at the falling edge after the write edge.
   task automatic wr(input int q, input int code, input bit sse);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 1'(q); reg_wdata = {sse, 3'(code)};
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic step();   // next sample point
      @(negedge clk); #5;
   endtask

   task automatic pulse_done(input int q);
      @(negedge clk); done_in[q] = 1'b1;
      @(negedge clk); done_in[q] = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      // R1 reset state
      chk("R1 all_off", all_off, 1);
      chk("R1 start", start_out, 0);
      chk("R1 active", active_out, 0);
      chk("R1 rdata", reg_rdata, 0);

      // Sweep every code on both queues (R2 R8 R12 R13 R3 readback)
      for (int q = 0; q < 2; q++) begin
         for (int code = 0; code < 8; code++) begin
            bit live;
            live = (code >= 1 && code <= 4) && !(q == 1 && code == 3);
            wr(q, code, 1'b1);
            #5;
            chk($sformatf("R12 all_off q%0d code%0d", q, code), all_off, live ? 0 : 1);
            chk($sformatf("R3 rdata q%0d code%0d", q, code), reg_rdata, code);
            cnt = start_out[q];
            for (int k = 0; k < 5; k++) begin
               @(negedge clk);
               if (k == 0) begin trig_in[q] = 1; gate_in[q] = 1; tick_in[q] = 1; end
               #5 cnt += start_out[q];
            end
            if (q == 1 && code == 3)
               chk("R8 gated on queue 2 starts", cnt, 0);
            else if (!live)
               chk($sformatf("R2 idle code %0d q%0d starts", code, q), cnt, 0);
            else
               chk($sformatf("R13 one start q%0d code%0d", q, code), cnt, 1);
            chk($sformatf("R2 active q%0d code%0d", q, code), active_out[q], live ? 1 : 0);
            pulse_done(q);
            trig_in[q] = 0; gate_in[q] = 0; tick_in[q] = 0;
            #5 chk($sformatf("R10 active after done q%0d code%0d", q, code), active_out[q], 0);
            wr(q, 0, 1'b0);
            repeat (4) @(negedge clk);
         end
      end

      // R4: external mode not armed ignores a trigger edge
      wr(0, 2, 1'b0);
      cnt = 0;
      @(negedge clk); trig_in[0] = 1;
      for (int k = 0; k < 4; k++) begin step(); cnt += start_out[0]; end
      chk("R4 unarmed trigger", cnt, 0);
      @(negedge clk); trig_in[0] = 0;
      repeat (3) @(negedge clk);

      // R6: armed, start exactly SYNC_STAGES cycles after the edge
      wr(0, 2, 1'b1);
      repeat (3) @(negedge clk);
      trig_in[0] = 1;
      @(negedge clk); #5 chk("R6 start early", start_out[0], 0);
      step(); chk("R6 start", start_out[0], 1);
      step(); chk("R6 pulse one cycle", start_out[0], 0);
      chk("R5 active after start", active_out[0], 1);
      cnt = 0;
      for (int k = 0; k < 4; k++) begin step(); cnt += start_out[0]; end
      chk("R6 held level", cnt, 0);
      pulse_done(0);
      trig_in[0] = 0;
      repeat (3) @(negedge clk);

      // R3: writing enable 0 does not disarm
      wr(0, 2, 1'b1);
      wr(0, 2, 1'b0);
      @(negedge clk); trig_in[0] = 1;
      cnt = 0;
      for (int k = 0; k < 4; k++) begin step(); cnt += start_out[0]; end
      chk("R3 enable write 0 no effect", cnt, 1);
      pulse_done(0);
      trig_in[0] = 0;
      repeat (3) @(negedge clk);

      // R10: after completion a new edge is ignored
      @(negedge clk); trig_in[0] = 1;
      cnt = 0;
      for (int k = 0; k < 4; k++) begin step(); cnt += start_out[0]; end
      chk("R10 retrigger ignored", cnt + active_out[0], 0);
      trig_in[0] = 0;
      wr(0, 0, 1'b0);

      // R5: software mode start the cycle after the arming write
      wr(0, 1, 1'b1);
      #5 chk("R5 start", start_out[0], 1);
      chk("R5 active before", active_out[0], 0);
      step(); chk("R5 pulse one cycle", start_out[0], 0);
      chk("R5 active", active_out[0], 1);
      pulse_done(0);
      cnt = 0;
      for (int k = 0; k < 3; k++) begin step(); cnt += start_out[0]; end
      chk("R10 software no restart", cnt, 0);
      wr(0, 0, 1'b0);

      // R7: gated mode pause and resume
      wr(0, 3, 1'b1);
      gate_in[0] = 1;
      @(negedge clk); step(); chk("R7 gate start", start_out[0], 1);
      step(); chk("R7 gate active", active_out[0], 1);
      gate_in[0] = 0;
      @(negedge clk); @(negedge clk); step();
      chk("R7 gate low drops active", active_out[0], 0);
      gate_in[0] = 1;
      @(negedge clk); step(); chk("R7 gate restart", start_out[0], 1);
      pulse_done(0);
      gate_in[0] = 0;
      wr(0, 0, 1'b0);
      repeat (3) @(negedge clk);

      // R9: interval tick starts in the same cycle
      wr(1, 4, 1'b1);
      #5 chk("R9 no start without tick", start_out[1], 0);
      @(negedge clk); tick_in[1] = 1;
      #5 chk("R9 tick start", start_out[1], 1);
      @(negedge clk); tick_in[1] = 0;
      #5 chk("R9 active", active_out[1], 1);

      // R11: completion and arming write in the same cycle
      @(negedge clk);
      done_in[1] = 1; reg_we = 1; reg_sel = 1'b1; reg_wdata = 4'b1100;
      @(negedge clk);
      done_in[1] = 0; reg_we = 0;
      #5 chk("R11 active cleared", active_out[1], 0);
      chk("R11 no start without tick", start_out[1], 0);
      @(negedge clk); tick_in[1] = 1;
      #5 chk("R11 arm survived", start_out[1], 1);
      @(negedge clk); tick_in[1] = 0;
      pulse_done(1);
      @(negedge clk); tick_in[1] = 1;
      #5 chk("R10 tick after done", start_out[1], 0);
      @(negedge clk); tick_in[1] = 0;
      #5 chk("R12 one queue live", all_off, 0);
      wr(1, 7, 1'b1);
      #5 chk("R12 reserved code idle", all_off, 1);

      report();
   end

endmodule